// File: doc/BRIEF.md
# Prescaled Countdown Interrupt Timer

This block is a programmable countdown timer. A prescaler divides the system clock by a power of two. Each prescaled tick steps a count down from a loaded start value, and when the count runs out the block raises a one-cycle interrupt request. The request carries an 8-bit vector taken from a control entry. The control entry also holds a mask flag and a periodic flag.

In one-shot mode the count stops at zero after a single expiry. In periodic mode the count reloads its start value, so the requests repeat. Software programs the block through one write port: an enable, a 2-bit register select and a 32-bit data word. It reads the live count and the two configuration registers through plain output ports. Address decoding on a bus and the acceptance of the request downstream belong to other blocks.

Top module: `cdt_timer`

## Requirements
- R1: A write with wr_sel = 1 sets the divide register. Only data bits 0, 1 and 3 are kept, and div_rd reads them back in the same positions with bit 2 always 0.
- R2: The divide code is {bit3, bit1, bit0}. The prescale shift is (code + 1) mod 8, and the count steps once every 2^shift clocks. Write value 0xB divides by 1, 0x0 by 2, 0x3 by 16 and 0x8 by 32.
- R3: A write with wr_sel = 2 sets the control entry. Bit 17 selects periodic mode, bit 16 masks requests and bits 7:0 are the vector. irq_vector shows the vector while irq_valid is high.
- R4: In one-shot mode the count falls by one per tick to zero, and a request is raised on the tick after zero is reached. A start value N at divide P gives the request (N+1)*P clocks after the start write. The count then stays at zero and no further request follows.
- R5: In periodic mode the count reloads the start value on the tick that finds it at zero. Requests repeat every (N+1)*P clocks, and the count reads N in the cycle the request is shown.
- R6: A start value of zero produces no request in either mode.
- R7: A write with wr_sel = 0 loads the count with the data at once and restarts the prescaler phase. Any countdown in progress is abandoned.
- R8: While the mask bit is set, no request is raised, but the count still runs.
- R9: After reset the control entry reads 0x0001_0000 (masked), the divide register reads 0, the count reads 0 and irq_valid is low.
- R10: A write with wr_sel = 3, the current-count slot, changes nothing.
- R11: irq_valid is high for exactly one clock per expiry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select: 0 start count, 1 divide, 2 control entry, 3 current count (no effect) |
| wr_data | input | 32 | Write data |
| cur_count | output | 32 | Live count value |
| div_rd | output | 4 | Divide register readback |
| entry_rd | output | 32 | Control entry readback |
| irq_valid | output | 1 | One-cycle interrupt request |
| irq_vector | output | 8 | Vector carried with the request |

## Verification
A wrong prescale shift or a wrong divide code shows up as a request that arrives too early or too late by a whole multiple of the divide ratio. The bench measures the request time in clocks from the start write, so such an error is caught on the first expiry. A wrong reload or disarm decision appears within one period, either as a missing second request in periodic mode or as an extra request after a one-shot expiry. A count that is stepped at the wrong moment is visible on cur_count within a few clocks of the start write.

// File: rtl/cdt_pkg.sv
package cdt_pkg;

  localparam int unsigned CNT_W  = 32;
  localparam int unsigned VEC_W  = 8;
  localparam int unsigned CODE_W = 3;
  localparam int unsigned PRE_W  = 8;

  // control entry field positions
  localparam int unsigned ENT_PERIODIC = 17;
  localparam int unsigned ENT_MASK     = 16;

  typedef enum logic [1:0] {
    SEL_START = 2'd0,
    SEL_DIV   = 2'd1,
    SEL_ENTRY = 2'd2,
    SEL_CUR   = 2'd3
  } wr_sel_e;

  // divide code -> prescale shift, wrapping at 8
  function automatic logic [CODE_W-1:0] shift_of(input logic [CODE_W-1:0] code);
    return code + CODE_W'(1);
  endfunction

  // low mask of 2^shift - 1
  function automatic logic [PRE_W-1:0] phase_mask(input logic [CODE_W-1:0] shift);
    return (PRE_W'(1) << shift) - PRE_W'(1);
  endfunction

endpackage

// File: rtl/cdt_cfg_regs.sv
module cdt_cfg_regs
  import cdt_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                div_we,
  input  logic [CODE_W-1:0]   div_code_in,
  input  logic                entry_we,
  input  logic                periodic_in,
  input  logic                mask_in,
  input  logic [VEC_W-1:0]    vector_in,
  output logic [CODE_W-1:0]   div_code,
  output logic                periodic,
  output logic                masked,
  output logic [VEC_W-1:0]    vector
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      div_code <= '0;
      periodic <= 1'b0;
      masked   <= 1'b1;
      vector   <= '0;
    end else begin
      if (div_we) div_code <= div_code_in;
      if (entry_we) begin
        periodic <= periodic_in;
        masked   <= mask_in;
        vector   <= vector_in;
      end
    end
  end

endmodule

// File: rtl/cdt_prescaler.sv
module cdt_prescaler
  import cdt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              restart,
  input  logic [CODE_W-1:0] shift,
  output logic              tick
);

  logic [PRE_W-1:0] phase_q;
  logic [PRE_W-1:0] mask_w;

  assign mask_w = phase_mask(shift);
  assign tick   = ((phase_q & mask_w) == mask_w) && !restart;

  always_ff @(posedge clk) begin
    if (!rst_n || restart) phase_q <= '0;
    else                   phase_q <= phase_q + PRE_W'(1);
  end

endmodule

// File: rtl/cdt_counter.sv
module cdt_counter
  import cdt_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             tick,
  input  logic             periodic,
  input  logic             masked,
  input  logic [VEC_W-1:0] vector_in,
  output logic [CNT_W-1:0] count,
  output logic             expire,
  output logic             irq_valid,
  output logic [VEC_W-1:0] irq_vector
);

  logic [CNT_W-1:0] reload_q;
  logic             armed_q;
  logic             at_zero;

  assign at_zero = (count == '0);
  assign expire  = tick && at_zero && armed_q && !load;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count    <= '0;
      reload_q <= '0;
      armed_q  <= 1'b0;
    end else if (load) begin
      count    <= load_val;
      reload_q <= load_val;
      armed_q  <= (load_val != '0);
    end else if (tick) begin
      if (!at_zero)      count <= count - CNT_W'(1);
      else if (armed_q) begin
        if (periodic)    count <= reload_q;
        else             armed_q <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq_valid  <= 1'b0;
      irq_vector <= '0;
    end else begin
      irq_valid  <= expire && !masked;
      if (expire) irq_vector <= vector_in;
    end
  end

endmodule

// File: rtl/cdt_timer.sv
module cdt_timer
  import cdt_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [1:0]  wr_sel,
  input  logic [31:0] wr_data,
  output logic [31:0] cur_count,
  output logic [3:0]  div_rd,
  output logic [31:0] entry_rd,
  output logic        irq_valid,
  output logic [7:0]  irq_vector
);

  logic              start_we, div_we, entry_we;
  logic [CODE_W-1:0] div_code;
  logic [CODE_W-1:0] shift_w;
  logic              periodic, masked;
  logic [VEC_W-1:0]  vector;
  logic              pre_tick;
  logic              expire_w;

  assign start_we = wr_en && (wr_sel_e'(wr_sel) == SEL_START);
  assign div_we   = wr_en && (wr_sel_e'(wr_sel) == SEL_DIV);
  assign entry_we = wr_en && (wr_sel_e'(wr_sel) == SEL_ENTRY);

  cdt_cfg_regs u_cfg (
    .clk         (clk),
    .rst_n       (rst_n),
    .div_we      (div_we),
    .div_code_in ({wr_data[3], wr_data[1:0]}),
    .entry_we    (entry_we),
    .periodic_in (wr_data[ENT_PERIODIC]),
    .mask_in     (wr_data[ENT_MASK]),
    .vector_in   (wr_data[VEC_W-1:0]),
    .div_code    (div_code),
    .periodic    (periodic),
    .masked      (masked),
    .vector      (vector)
  );

  assign shift_w = shift_of(div_code);

  cdt_prescaler u_pre (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (start_we),
    .shift   (shift_w),
    .tick    (pre_tick)
  );

  cdt_counter u_cnt (
    .clk        (clk),
    .rst_n      (rst_n),
    .load       (start_we),
    .load_val   (wr_data),
    .tick       (pre_tick),
    .periodic   (periodic),
    .masked     (masked),
    .vector_in  (vector),
    .count      (cur_count),
    .expire     (expire_w),
    .irq_valid  (irq_valid),
    .irq_vector (irq_vector)
  );

  assign div_rd = {div_code[2], 1'b0, div_code[1:0]};

  always_comb begin
    entry_rd               = '0;
    entry_rd[ENT_PERIODIC] = periodic;
    entry_rd[ENT_MASK]     = masked;
    entry_rd[VEC_W-1:0]    = vector;
  end

endmodule

// File: rtl/cdt_checker.sv
module cdt_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        wr_en,
  input logic [1:0]  wr_sel,
  input logic [31:0] wr_data,
  input logic [31:0] cur_count,
  input logic [31:0] entry_rd,
  input logic        irq_valid,
  input logic [7:0]  irq_vector,
  input logic        tick,
  input logic        expire
);

  logic load_w;
  assign load_w = wr_en && (wr_sel == 2'd0);

  AST_IRQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid |=> !irq_valid); // R11

  AST_MASK_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    entry_rd[16] |=> !irq_valid); // R8

  AST_VECTOR_CARRIED: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && !entry_rd[16]) |=> (irq_valid && irq_vector == $past(entry_rd[7:0]))); // R3

  AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_w && !tick) |=> $stable(cur_count)); // R4

  AST_START_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    load_w |=> cur_count == $past(wr_data)); // R7

  AST_EXPIRE_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    expire |-> cur_count == 32'd0); // R6

endmodule

bind cdt_timer cdt_checker u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .wr_en      (wr_en),
  .wr_sel     (wr_sel),
  .wr_data    (wr_data),
  .cur_count  (cur_count),
  .entry_rd   (entry_rd),
  .irq_valid  (irq_valid),
  .irq_vector (irq_vector),
  .tick       (pre_tick),
  .expire     (expire_w)
);

// File: tb/test_cdt_timer.sv
module test_cdt_timer;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_sel = 2'd0;
  logic [31:0] wr_data = '0;
  logic [31:0] cur_count;
  logic [3:0]  div_rd;
  logic [31:0] entry_rd;
  logic        irq_valid;
  logic [7:0]  irq_vector;

  int n_checks = 0;
  int n_fail   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cdt_timer i_cdt_timer (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .cur_count(cur_count), .div_rd(div_rd), .entry_rd(entry_rd),
    .irq_valid(irq_valid), .irq_vector(irq_vector)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic reg_write(input logic [1:0] sel, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0;
  endtask

  // returns clocks from the start write until irq_valid is seen, -1 if none
  task automatic wait_irq(input int limit, output int k);
    k = -1;
    for (int i = 1; i <= limit; i++) begin
      @(negedge clk);
      if (irq_valid) begin k = i; return; end
    end
  endtask

  task automatic t_reset;
    check("R9 entry", entry_rd, 32'h0001_0000);
    check("R9 div", {28'd0, div_rd}, 32'd0);
    check("R9 count", cur_count, 32'd0);
    check("R9 irq", {31'd0, irq_valid}, 32'd0);
  endtask

  task automatic t_reset_divide;
    int k;
    reg_write(2'd2, 32'h0000_0011);
    reg_write(2'd0, 32'd3);
    wait_irq(40, k);
    check("R9 R2 divide-by-2 timing", k, 32'd8);
    check("R3 vector", {24'd0, irq_vector}, 32'h11);
  endtask

  task automatic t_div_bits;
    reg_write(2'd1, 32'hFFFF_FF4F);
    check("R1 readback", {28'd0, div_rd}, 32'hB);
    reg_write(2'd1, 32'h0000_000C);
    check("R1 bit2 dropped", {28'd0, div_rd}, 32'h8);
  endtask

  task automatic t_div_ratios;
    int k;
    reg_write(2'd2, 32'h0000_0022);
    reg_write(2'd1, 32'h8);
    reg_write(2'd0, 32'd2);
    wait_irq(200, k);
    check("R2 divide-by-32", k, 32'd96);
    reg_write(2'd1, 32'h3);
    reg_write(2'd0, 32'd1);
    wait_irq(200, k);
    check("R2 divide-by-16", k, 32'd32);
  endtask

  task automatic t_oneshot;
    int k;
    reg_write(2'd1, 32'hB);
    reg_write(2'd2, 32'h0000_0042);
    reg_write(2'd0, 32'd5);
    repeat (3) @(negedge clk);
    check("R4 count mid", cur_count, 32'd2);
    wait_irq(20, k);
    check("R4 one-shot timing", k, 32'd3);
    check("R3 vector one-shot", {24'd0, irq_vector}, 32'h42);
    @(negedge clk);
    check("R11 pulse width", {31'd0, irq_valid}, 32'd0);
    wait_irq(30, k);
    check("R4 no second request", k, 32'hFFFF_FFFF);
    check("R4 count held at zero", cur_count, 32'd0);
  endtask

  task automatic t_periodic;
    int k;
    reg_write(2'd2, 32'h0002_0077);
    reg_write(2'd0, 32'd4);
    wait_irq(20, k);
    check("R5 first period", k, 32'd5);
    check("R5 reloaded count", cur_count, 32'd4);
    for (int p = 0; p < 2; p++) begin
      wait_irq(20, k);
      check("R5 repeat period", k, 32'd5);
    end
    reg_write(2'd0, 32'd0);
    wait_irq(40, k);
    check("R6 zero start periodic", k, 32'hFFFF_FFFF);
    check("R6 count stays zero", cur_count, 32'd0);
  endtask

  task automatic t_masked;
    int k;
    reg_write(2'd2, 32'h0001_0055);
    reg_write(2'd0, 32'd3);
    wait_irq(20, k);
    check("R8 masked silent", k, 32'hFFFF_FFFF);
    check("R8 count still ran", cur_count, 32'd0);
  endtask

  task automatic t_restart;
    int k;
    reg_write(2'd2, 32'h0000_0042);
    reg_write(2'd0, 32'd10);
    repeat (4) @(negedge clk);
    check("R7 progress", cur_count, 32'd6);
    reg_write(2'd0, 32'd2);
    check("R7 reloaded", cur_count, 32'd2);
    wait_irq(20, k);
    check("R7 restart timing", k, 32'd3);
  endtask

  task automatic t_cur_write;
    reg_write(2'd0, 32'd20);
    repeat (2) @(negedge clk);
    check("R10 before", cur_count, 32'd18);
    reg_write(2'd3, 32'd5);
    check("R10 write ignored", cur_count, 32'd16);
    check("R10 entry unchanged", entry_rd, 32'h0000_0042);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_reset_divide;
    t_div_bits;
    t_div_ratios;
    t_oneshot;
    t_periodic;
    t_masked;
    t_restart;
    t_cur_write;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule